// File: doc/BRIEF.md
# PHY Management Register Bridge

This block lets software reach the internal registers of an external Ethernet PHY through one 32-bit host register. A host write to the register launches a single serial management transaction on the MDC/MDIO pair. The host then polls the register's top bit to learn when the access is over. For a read, the returned 16-bit value appears in the low half of the same register.

The top bit has a different meaning for each direction. To write a PHY register, software sets the bit together with the address and data. Hardware clears the bit when the frame has been shifted out. To read, software writes the bit as zero. Hardware sets it once the data is valid.

MDC comes from a divider on the system clock, and the divider is sized from two parameters so that MDC never runs faster than the limit. The PHY address is a fixed parameter.

Top module: `phy_mgmt_bridge`

## Requirements
- R1: After reset the host register reads 0. At any time it reads {flag at bit 31, zeros at bits 30:21, register address at bits 20:16, data at bits 15:0}.
- R2: A host write with bit 31 = 1 while idle starts a write access. The flag reads 1 from the cycle after the host write until the frame ends, and then reads 0. Bits 15:0 keep the written data.
- R3: A host write with bit 31 = 0 while idle starts a read access. The flag reads 0 while the read runs. When the read ends, the flag reads 1 and bits 15:0 hold the 16 bits returned by the PHY.
- R4: Each frame is 64 MDC bits, changed after MDC falls. The bits are, in order: 32 ones; start 01; opcode 01 for a write or 10 for a read; the 5-bit PHY address parameter, MSB first; the register address bits 20:16, MSB first; then, for a write, turnaround 10 and the 16 data bits MSB first.
- R5: In a read frame, the output enable is low from bit 46 to the end of the frame. The bridge samples mdio_i on each MDC rising edge of bits 48 to 63 and assembles the value MSB first.
- R6: A host write that arrives while an access is in progress has no effect. It does not change the register contents or the frame being sent.
- R7: MDC high and low phases within a frame each last HALF system clocks, where HALF = ceil(CLK_HZ / (2 * MDC_MAX_HZ)). With the defaults HALF is 40, which gives 2.5 MHz from 200 MHz. When idle, MDC and the output enable are low.
- R8: Host address bits 23:21 are ignored. They do not appear in the frame and they read back as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Write strobe for the access register |
| host_wdata | input | 32 | Write data for the access register |
| host_rdata | output | 32 | Current contents of the access register |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven towards the PHY |
| mdio_oe | output | 1 | Output enable for mdio_o |
| mdio_i | input | 1 | Management data from the PHY |

## Verification
Some rules are checked by assertions on every cycle:
- MDC toggles only at the end of a full divider count.
- MDC stays low while idle.
- The preamble drives ones.
- A new access never starts while another is in progress.
- A host write made during an access leaves the stored address unchanged.
- At completion the flag clears for a write and sets with the captured data for a read.

Other behaviour only the bench scenarios can show: the exact bit order of each frame, the released turnaround in reads, the MSB-first assembly of the PHY's reply, the masking of the upper address bits, and the measured MDC phase lengths. The bench shows these by decoding the wire activity against a PHY model.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int TA_POS     = 46;
  localparam int DATA_POS   = 48;

  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic        is_wr,
    input logic [4:0]  phy,
    input logic [4:0]  regad,
    input logic [15:0] data
  );
    logic [17:0] tail;
    tail = is_wr ? {2'b10, data} : 18'h3FFFF;
    return {32'hFFFF_FFFF, 2'b01, (is_wr ? 2'b01 : 2'b10), phy, regad, tail};
  endfunction
endpackage

// File: rtl/mdc_divider.sv
module mdc_divider #(
  parameter int HALF = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          wrap;

  assign wrap = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc       = mdc_q;
  assign rise_tick = wrap && !mdc_q;
  assign fall_tick = wrap && mdc_q;

  // R7: MDC only toggles after a full half-period count
  a_r7_half_period: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc_q != $past(mdc_q)) |-> ($past(cnt_q) == LAST));
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import phy_mgmt_pkg::*;
#(
  parameter logic [4:0] PHY_ADDR = 5'h01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        start_write,
  input  logic [4:0]  start_reg,
  input  logic [15:0] start_data,
  input  logic        rise_tick,
  input  logic        fall_tick,
  input  logic        mdio_i,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        mdio_o,
  output logic        mdio_oe
);
  localparam int IW = $clog2(FRAME_BITS);
  localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_BITS - 1);

  logic                  busy_q, busy_d;
  logic                  wr_q, wr_d;
  logic [FRAME_BITS-1:0] sr_q, sr_d;
  logic [IW-1:0]         idx_q, idx_d;
  logic [15:0]           rx_q, rx_d;

  assign done = busy_q && fall_tick && (idx_q == LAST_IDX);

  always_comb begin
    busy_d = busy_q;
    wr_d   = wr_q;
    sr_d   = sr_q;
    idx_d  = idx_q;
    rx_d   = rx_q;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      wr_d   = start_write;
      sr_d   = build_frame(start_write, PHY_ADDR, start_reg, start_data);
      idx_d  = '0;
    end else if (busy_q) begin
      if (rise_tick && !wr_q && (idx_q >= IW'(DATA_POS)))
        rx_d = {rx_q[14:0], mdio_i};
      if (fall_tick) begin
        if (idx_q == LAST_IDX) begin
          busy_d = 1'b0;
        end else begin
          idx_d = idx_q + 1'b1;
          sr_d  = {sr_q[FRAME_BITS-2:0], 1'b1};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      sr_q   <= '0;
      idx_q  <= '0;
      rx_q   <= '0;
    end else begin
      busy_q <= busy_d;
      wr_q   <= wr_d;
      sr_q   <= sr_d;
      idx_q  <= idx_d;
      rx_q   <= rx_d;
    end
  end

  assign busy    = busy_q;
  assign rd_data = rx_q;
  assign mdio_o  = busy_q ? sr_q[FRAME_BITS-1] : 1'b0;
  assign mdio_oe = busy_q && (wr_q || (idx_q < IW'(TA_POS)));

  // R4: the preamble drives ones on the wire
  a_r4_preamble_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (idx_q < IW'(PRE_BITS))) |-> (mdio_o && mdio_oe));
  // R6: the register stage never launches into a running frame
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);
  // R2: the frame ends after its completion pulse
  a_r2_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q);
endmodule

// File: rtl/phy_access_reg.sv
module phy_access_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [31:0] wdata,
  input  logic        busy,
  input  logic        done,
  input  logic [15:0] rd_data,
  output logic        start,
  output logic        start_write,
  output logic [4:0]  start_reg,
  output logic [15:0] start_data,
  output logic [31:0] rdata
);
  logic        flag_q, flag_d;
  logic        op_q, op_d;
  logic [4:0]  addr_q, addr_d;
  logic [15:0] data_q, data_d;
  logic        unused_bits;

  assign unused_bits = ^wdata[30:21];
  assign start       = wr && !busy;
  assign start_write = wdata[31];
  assign start_reg   = wdata[20:16];
  assign start_data  = wdata[15:0];

  always_comb begin
    flag_d = flag_q;
    op_d   = op_q;
    addr_d = addr_q;
    data_d = data_q;
    if (start) begin
      flag_d = wdata[31];
      op_d   = wdata[31];
      addr_d = wdata[20:16];
      data_d = wdata[15:0];
    end else if (done) begin
      if (op_q) begin
        flag_d = 1'b0;
      end else begin
        flag_d = 1'b1;
        data_d = rd_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      op_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      flag_q <= flag_d;
      op_q   <= op_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign rdata = {flag_q, 10'b0, addr_q, data_q};

  // R6: a host write during an access leaves the address alone
  a_r6_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && busy) |=> $stable(addr_q));
  // R2: a finished write clears the flag
  a_r2_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q) |=> !flag_q);
  // R3: a finished read sets the flag and loads the captured data
  a_r3_read_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !op_q) |=> (flag_q && (data_q == $past(rd_data))));
endmodule

// File: rtl/phy_mgmt_bridge.sv
module phy_mgmt_bridge #(
  parameter int         CLK_HZ      = 200_000_000,
  parameter int         MDC_MAX_HZ  = 2_500_000,
  parameter logic [4:0] PHY_ADDR    = 5'h01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int HALF_RAW = (CLK_HZ + 2 * MDC_MAX_HZ - 1) / (2 * MDC_MAX_HZ);
  localparam int HALF     = (HALF_RAW < 1) ? 1 : HALF_RAW;

  logic        start, start_write, busy, done;
  logic        rise_tick, fall_tick;
  logic [4:0]  start_reg;
  logic [15:0] start_data, rd_data;

  phy_access_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr(host_wr), .wdata(host_wdata),
    .busy(busy), .done(done), .rd_data(rd_data),
    .start(start), .start_write(start_write), .start_reg(start_reg),
    .start_data(start_data), .rdata(host_rdata)
  );

  mdc_divider #(.HALF(HALF)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_engine #(.PHY_ADDR(PHY_ADDR)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .start_write(start_write),
    .start_reg(start_reg), .start_data(start_data),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
    .busy(busy), .done(done), .rd_data(rd_data),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  // R7: MDC and the output enable rest low between accesses
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));
endmodule

// File: tb/phy_mgmt_bridge_tb.sv
`timescale 1ns/1ps
module phy_mgmt_bridge_tb;
  localparam logic [4:0] PHY = 5'h01;
  localparam int HALF = 40;
  localparam int NV = 7;
  // {is_write, host address byte, write data, expected read value}
  localparam logic [40:0] VEC [NV] = '{
    {1'b1, 8'h04, 16'h01E1, 16'h0000},
    {1'b0, 8'h04, 16'h0000, 16'h01E1},
    {1'b1, 8'h09, 16'h0200, 16'h0000},
    {1'b0, 8'hE9, 16'h0000, 16'h0200},
    {1'b1, 8'h1F, 16'hA5C3, 16'h0000},
    {1'b0, 8'h1F, 16'h0000, 16'hA5C3},
    {1'b0, 8'h02, 16'h0000, 16'h001C}
  };

  logic clk = 1'b0, rst_n = 1'b0, host_wr = 1'b0, mdio_i = 1'b1;
  logic [31:0] host_wdata = '0, host_rdata;
  logic mdc, mdio_o, mdio_oe;
  int checks = 0, errors = 0;
  bit finished = 0;

  logic [15:0] phy_mem [32];
  logic [63:0] cap = '0, oecap = '0;
  int bitn = 0, run_len = 0;
  logic mdc_d = 1'b0, oe_d = 1'b0, lo_ok = 1'b0;
  logic [4:0] rreg = '0;
  int hi_min = 1000, hi_max = 0, lo_min = 1000, lo_max = 0;

  phy_mgmt_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  always #2.5 clk = ~clk;

  // PHY model and wire monitor, sampled away from the active edge
  always @(negedge clk) begin
    mdc_d <= mdc;
    oe_d  <= mdio_oe;
    if (mdc == mdc_d) run_len <= run_len + 1;
    else run_len <= 1;
    if (mdio_oe && !oe_d) begin
      bitn  <= 0;
      lo_ok <= 1'b0;
    end else if (mdc && !mdc_d) begin
      cap    <= {cap[62:0], mdio_o};
      oecap  <= {oecap[62:0], mdio_oe};
      bitn   <= bitn + 1;
      lo_ok  <= 1'b0;
      if (lo_ok) begin
        if (run_len < lo_min) lo_min <= run_len;
        if (run_len > lo_max) lo_max <= run_len;
      end
    end else if (!mdc && mdc_d) begin
      lo_ok <= 1'b1;
      if (run_len < hi_min) hi_min <= run_len;
      if (run_len > hi_max) hi_max <= run_len;
      if (bitn == 46) rreg <= cap[4:0];
      if (bitn == 47) mdio_i <= 1'b0;
      else if (bitn >= 48 && bitn < 64) mdio_i <= phy_mem[rreg][63-bitn];
      else mdio_i <= 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [31:0] w);
    @(negedge clk);
    host_wr = 1'b1;
    host_wdata = w;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic wait_done(input bit is_wr);
    for (int i = 0; i < 12000; i++) begin
      @(negedge clk);
      if (host_rdata[31] != is_wr) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic run_access(input bit w, input logic [7:0] a, input logic [15:0] d,
                            input logic [15:0] exp_rd);
    logic [63:0] ef;
    logic [31:0] er;
    host_write({w, 7'b0, a, d});
    // R2 / R3: flag value while the access runs
    chk(host_rdata[31] == w, w ? "R2 flag busy" : "R3 flag busy", 64'(host_rdata[31]), 64'(w));
    wait_done(w);
    ef = {32'hFFFF_FFFF, 2'b01, (w ? 2'b01 : 2'b10), PHY, a[4:0], (w ? {2'b10, d} : 18'h0)};
    if (w) begin
      er = {1'b0, 10'b0, a[4:0], d};
      chk(host_rdata == er, "R2 readback", 64'(host_rdata), 64'(er));
      chk(cap == ef, "R4 write frame", cap, ef);
      chk(oecap == '1, "R4 write drive", oecap, '1);
      if (cap[29:28] == 2'b01) phy_mem[cap[22:18]] = cap[15:0];
    end else begin
      er = {1'b1, 10'b0, a[4:0], exp_rd};
      chk(host_rdata == er, "R3 R8 read result", 64'(host_rdata), 64'(er));
      chk(cap[63:18] == ef[63:18], "R4 R8 read header", 64'(cap[63:18]), 64'(ef[63:18]));
      chk(oecap == {{46{1'b1}}, 18'h0}, "R5 turnaround release", oecap, {{46{1'b1}}, 18'h0});
    end
    chk(bitn == 64, "R4 frame length", 64'(bitn), 64'd64);
    chk(!mdc && !mdio_oe, "R7 idle", {62'b0, mdc, mdio_oe}, 64'd0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    for (int i = 0; i < 32; i++) phy_mem[i] = 16'h0000;
    phy_mem[2] = 16'h001C;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(host_rdata == 32'h0, "R1 reset value", 64'(host_rdata), 64'd0);
    chk(!mdc && !mdio_oe, "R7 reset idle", {62'b0, mdc, mdio_oe}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++)
      run_access(VEC[v][40], VEC[v][39:32], VEC[v][31:16], VEC[v][15:0]);

    // R6: host write during a running write is ignored
    host_write(32'h8003_1234);
    repeat (500) @(negedge clk);
    host_write(32'h0007_FFFF);
    chk(host_rdata == 32'h8003_1234, "R6 ignored mid-access", 64'(host_rdata), 64'h80031234);
    wait_done(1'b1);
    chk(host_rdata == 32'h0003_1234, "R6 result kept", 64'(host_rdata), 64'h00031234);
    chk(cap[15:0] == 16'h1234 && cap[22:18] == 5'd3, "R6 frame kept",
        {41'b0, cap[22:18], 2'b0, cap[15:0]}, {41'b0, 5'd3, 2'b0, 16'h1234});

    // R7: MDC phase lengths
    chk(hi_min == HALF && hi_max == HALF, "R7 high phase", {hi_min[31:0], hi_max[31:0]}, {32'(HALF), 32'(HALF)});
    chk(lo_min == HALF && lo_max == HALF, "R7 low phase", {lo_min[31:0], lo_max[31:0]}, {32'(HALF), 32'(HALF)});

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule